// File: doc/BRIEF.md
# Dual-Mode Stack Cycle Generator

This block produces the stack bus cycles of a processor core that can run either in an 8-bit compatible emulation mode or in its native 16-bit mode. It owns the 16-bit stack pointer. It accepts one command at a time, either a single stack micro-operation or a fixed multi-cycle sequence for one instruction. It issues one bus cycle per clock, with an address, a write strobe, a read strobe and write data. Bytes read from the stack are captured into a three-lane byte buffer.

Every single push or pull comes in two forms. The mode-respecting form keeps the stack inside page one while emulation is active: the address high byte is forced to 0x01 and only the low byte of the pointer wraps. The full-width form always uses and updates all 16 pointer bits, whatever the emulation flag says. The instruction sequences built in here (push and pull of the direct register, push of an effective address, long call and long return) use only full-width accesses. The operand bytes for pushes come from a 24-bit operand input that is latched when the command is accepted: lane 0 is bits 7:0, lane 1 is bits 15:8 and lane 2 is bits 23:16.

Top module: `stk_cycle_gen`

## Requirements
- R1: After reset the stack pointer reads 0x01FF, busy and done are low, neither strobe is active and the read buffer is zero.
- R2: A push (code 1 mode-respecting, code 2 full-width) takes one cycle. It drives the write strobe with the operand lane 0 byte on the write data, at an address equal to the pointer. The pointer is one lower afterwards.
- R3: A pull (code 3 mode-respecting, code 4 full-width) takes one cycle. It adds one to the pointer, drives the read strobe at that incremented address and stores the read byte in buffer lane 0.
- R4: With emulation set, a mode-respecting push or pull puts 0x01 on address bits 15:8, wraps only the pointer's low byte (0x00 to 0xFF and back), and leaves the pointer's high byte unchanged.
- R5: Full-width pushes and pulls use and update the whole 16-bit pointer whether emulation is set or clear.
- R6: A conditional pull (code 5) acts as a mode-respecting pull when emulation is clear. When emulation is set it makes no bus cycle, busy stays low, done is high in the cycle it is offered and the pointer does not change.
- R7: Push-direct (code 6) makes one idle cycle with neither strobe and the address equal to the pointer. It then makes full-width pushes of operand lane 1 and then lane 0.
- R8: Pull-direct (code 7) makes two idle cycles and then full-width pulls into buffer lane 0 and then lane 1.
- R9: Push-effective-address (code 8) makes full-width pushes of operand lane 1 and then lane 0, with no idle cycle.
- R10: Long call (code 9) makes full-width pushes of operand lane 2 (bank), then lane 1, then lane 0.
- R11: Long return (code 10) makes two idle cycles and then full-width pulls into buffer lanes 0, 1 and 2, in that order.
- R12: The debug pointer output always shows the stored 16-bit value unmodified, including a high byte other than 0x01 after a full-width access in emulation. A load loads the given value, with the high byte replaced by 0x01 while emulation is set. A load takes priority, so a command offered in the same cycle is not accepted.
- R13: A rising edge of the emulation flag sets the pointer's high byte to 0x01 at the next clock edge.
- R14: Busy is high from the cycle after acceptance through the last step. Done is high only in the last step. Commands offered while busy are ignored, and codes 11 to 15 are never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu | input | 1 | Emulation flag |
| sp_load | input | 1 | Load the stack pointer |
| sp_load_val | input | 16 | Value to load |
| cmd_valid | input | 1 | Command offered |
| cmd | input | 4 | Command code |
| op_data | input | 24 | Operand bytes for pushes, three lanes |
| bus_rdata | input | 8 | Read data from memory |
| bus_addr | output | 16 | Stack bus address |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wdata | output | 8 | Write data |
| rd_buf | output | 24 | Captured pull bytes, three lanes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last step of a command, or a skipped pull |
| sp_dbg | output | 16 | Stored stack pointer |

## Verification
Directed cases put the pointer on the page-one edges 0x0100 and 0x01FF with emulation set. These separate low-byte wrap from a full 16-bit borrow or carry, and show whether the high byte is held or altered. One full-width push in emulation leaves a high byte of 0x00, which the debug output must show as is. Conditional pulls are offered with emulation set and with it clear, so the skip path is told apart from a real pull. Random commands, loads and emulation toggles then run against a bench model. Each step is checked for address, strobes, write data and lane order, while junk commands are offered during busy cycles.

// File: rtl/stk_pkg.sv
package stk_pkg;

   localparam int unsigned MAX_STEPS = 5;
   localparam int unsigned NLANE     = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PUSH = 2'd1,
      ST_PULL = 2'd2
   } st_kind_e;

   typedef struct packed {
      st_kind_e   kind;
      logic       full;
      logic [1:0] lane;
   } step_t;

   typedef struct packed {
      logic [2:0]                 len;
      step_t [MAX_STEPS-1:0]      st;
   } seq_t;

   localparam logic [3:0] CMD_IDLE   = 4'd0;
   localparam logic [3:0] CMD_PUSH_M = 4'd1;
   localparam logic [3:0] CMD_PUSH_F = 4'd2;
   localparam logic [3:0] CMD_PULL_M = 4'd3;
   localparam logic [3:0] CMD_PULL_F = 4'd4;
   localparam logic [3:0] CMD_PULL_C = 4'd5;
   localparam logic [3:0] CMD_PHDIR  = 4'd6;
   localparam logic [3:0] CMD_PLDIR  = 4'd7;
   localparam logic [3:0] CMD_PEFF   = 4'd8;
   localparam logic [3:0] CMD_LCALL  = 4'd9;
   localparam logic [3:0] CMD_LRET   = 4'd10;

   function automatic step_t mk(st_kind_e k, logic f, logic [1:0] l);
      step_t s;
      s.kind = k;
      s.full = f;
      s.lane = l;
      return s;
   endfunction

   function automatic logic cmd_known(logic [3:0] c);
      return c <= CMD_LRET;
   endfunction

   function automatic seq_t seq_of(logic [3:0] c);
      seq_t q;
      for (int i = 0; i < MAX_STEPS; i++) q.st[i] = mk(ST_IDLE, 1'b0, 2'd0);
      q.len = 3'd1;
      case (c)
         CMD_PUSH_M: q.st[0] = mk(ST_PUSH, 1'b0, 2'd0);
         CMD_PUSH_F: q.st[0] = mk(ST_PUSH, 1'b1, 2'd0);
         CMD_PULL_M,
         CMD_PULL_C: q.st[0] = mk(ST_PULL, 1'b0, 2'd0);
         CMD_PULL_F: q.st[0] = mk(ST_PULL, 1'b1, 2'd0);
         CMD_PHDIR: begin
            q.len   = 3'd3;
            q.st[1] = mk(ST_PUSH, 1'b1, 2'd1);
            q.st[2] = mk(ST_PUSH, 1'b1, 2'd0);
         end
         CMD_PLDIR: begin
            q.len   = 3'd4;
            q.st[2] = mk(ST_PULL, 1'b1, 2'd0);
            q.st[3] = mk(ST_PULL, 1'b1, 2'd1);
         end
         CMD_PEFF: begin
            q.len   = 3'd2;
            q.st[0] = mk(ST_PUSH, 1'b1, 2'd1);
            q.st[1] = mk(ST_PUSH, 1'b1, 2'd0);
         end
         CMD_LCALL: begin
            q.len   = 3'd3;
            q.st[0] = mk(ST_PUSH, 1'b1, 2'd2);
            q.st[1] = mk(ST_PUSH, 1'b1, 2'd1);
            q.st[2] = mk(ST_PUSH, 1'b1, 2'd0);
         end
         CMD_LRET: begin
            q.len   = 3'd5;
            q.st[2] = mk(ST_PULL, 1'b1, 2'd0);
            q.st[3] = mk(ST_PULL, 1'b1, 2'd1);
            q.st[4] = mk(ST_PULL, 1'b1, 2'd2);
         end
         default: ;
      endcase
      return q;
   endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
   import stk_pkg::*;
#(
   parameter int unsigned           DW       = 8,
   parameter int unsigned           SPW      = 16,
   parameter logic [SPW-DW-1:0]     EMU_PAGE = 1,
   parameter logic [SPW-1:0]        RST_SP   = 16'h01FF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           emu,
   input  logic           load,
   input  logic [SPW-1:0] load_val,
   input  logic           act,
   input  step_t          step,
   output logic [SPW-1:0] sp,
   output logic [SPW-1:0] addr
);

   localparam int unsigned HW = SPW - DW;

   logic           emu_q;
   logic           wrap;
   logic           emu_rise;
   logic [DW-1:0]  lo_inc, lo_dec;
   logic [SPW-1:0] nxt, sp_d;

   assign wrap     = emu && !step.full;
   assign emu_rise = emu && !emu_q;
   assign lo_inc   = sp[DW-1:0] + 1'b1;
   assign lo_dec   = sp[DW-1:0] - 1'b1;

   always_comb begin
      addr = sp;
      nxt  = sp;
      if (act) begin
         case (step.kind)
            ST_PUSH: begin
               addr = wrap ? {EMU_PAGE, sp[DW-1:0]} : sp;
               nxt  = wrap ? {sp[SPW-1:DW], lo_dec} : sp - 1'b1;
            end
            ST_PULL: begin
               addr = wrap ? {EMU_PAGE, lo_inc} : sp + 1'b1;
               nxt  = wrap ? {sp[SPW-1:DW], lo_inc} : sp + 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      sp_d = load ? load_val : nxt;
      if (emu && (emu_rise || load)) sp_d[SPW-1:DW] = EMU_PAGE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp    <= RST_SP;
         emu_q <= 1'b0;
      end else begin
         sp    <= sp_d;
         emu_q <= emu;
      end
   end

   AST_PAGE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (act && step.kind != ST_IDLE && emu && !step.full) |-> addr[SPW-1:DW] == EMU_PAGE); // R4
   AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (act && step.kind != ST_IDLE && emu && emu_q && !step.full && !load)
      |=> sp[SPW-1:DW] == $past(sp[SPW-1:DW])); // R4
   AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (act && step.kind == ST_PUSH && step.full && !load && !emu_rise)
      |=> sp == SPW'($past(sp) - 1'b1)); // R5
   AST_EMU_HI: assert property (@(posedge clk) disable iff (!rst_n)
      emu_rise |=> sp[SPW-1:DW] == EMU_PAGE); // R13

   logic [HW-1:0] unused_hw;
   assign unused_hw = '0;

endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd,
   input  logic              emu,
   input  logic              hold,
   input  logic [NLANE*DW-1:0] opd_in,
   output logic              busy,
   output logic              done,
   output logic              act,
   output step_t             cur,
   output logic [NLANE*DW-1:0] opd
);

   seq_t       seq_q;
   logic [2:0] idx;
   logic       offer, skip, accept, last;

   assign offer  = cmd_valid && !busy && !hold && cmd_known(cmd);
   assign skip   = offer && cmd == CMD_PULL_C && emu;
   assign accept = offer && !skip;
   assign act    = busy;
   assign cur    = seq_q.st[idx];
   assign last   = busy && (idx == seq_q.len - 3'd1);
   assign done   = last || skip;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         seq_q <= '0;
         opd   <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         idx   <= '0;
         seq_q <= seq_of(cmd);
         opd   <= opd_in;
      end else if (busy) begin
         if (last) busy <= 1'b0;
         else      idx  <= idx + 3'd1;
      end
   end

   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |=> !busy); // R14
   AST_NO_SKIP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      skip |=> !busy); // R6

endmodule

// File: rtl/stk_rdbuf.sv
module stk_rdbuf
   import stk_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap,
   input  logic [1:0]          lane,
   input  logic [DW-1:0]       rdata,
   output logic [NLANE*DW-1:0] q
);

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [DW-1:0] r;
      always_ff @(posedge clk) begin
         if (!rst_n)                       r <= '0;
         else if (cap && lane == 2'(g))    r <= rdata;
      end
      assign q[g*DW +: DW] = r;
   end

endmodule

// File: rtl/stk_cycle_gen.sv
module stk_cycle_gen
   import stk_pkg::*;
#(
   parameter int unsigned       DW       = 8,
   parameter int unsigned       SPW      = 16,
   parameter logic [SPW-DW-1:0] EMU_PAGE = 1,
   parameter logic [SPW-1:0]    RST_SP   = 16'h01FF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                emu,
   input  logic                sp_load,
   input  logic [SPW-1:0]      sp_load_val,
   input  logic                cmd_valid,
   input  logic [3:0]          cmd,
   input  logic [NLANE*DW-1:0] op_data,
   input  logic [DW-1:0]       bus_rdata,
   output logic [SPW-1:0]      bus_addr,
   output logic                bus_wr,
   output logic                bus_rd,
   output logic [DW-1:0]       bus_wdata,
   output logic [NLANE*DW-1:0] rd_buf,
   output logic                busy,
   output logic                done,
   output logic [SPW-1:0]      sp_dbg
);

   if (SPW <= DW) begin : g_bad_width
      $error("stack pointer must be wider than a data byte");
   end
   if (RST_SP[SPW-1:DW] != EMU_PAGE) begin : g_bad_reset
      $error("reset pointer must lie in the emulation page");
   end

   logic                act;
   step_t               cur;
   logic [NLANE*DW-1:0] opd;

   stk_seq #(.DW(DW)) u_seq (
      .clk, .rst_n, .cmd_valid, .cmd, .emu,
      .hold   (sp_load),
      .opd_in (op_data),
      .busy, .done, .act, .cur, .opd
   );

   stk_ptr #(.DW(DW), .SPW(SPW), .EMU_PAGE(EMU_PAGE), .RST_SP(RST_SP)) u_ptr (
      .clk, .rst_n, .emu,
      .load     (sp_load),
      .load_val (sp_load_val),
      .act,
      .step     (cur),
      .sp       (sp_dbg),
      .addr     (bus_addr)
   );

   assign bus_wr    = act && cur.kind == ST_PUSH;
   assign bus_rd    = act && cur.kind == ST_PULL;
   assign bus_wdata = bus_wr ? opd[int'(cur.lane)*DW +: DW] : '0;

   stk_rdbuf #(.DW(DW)) u_buf (
      .clk, .rst_n,
      .cap   (bus_rd),
      .lane  (cur.lane),
      .rdata (bus_rdata),
      .q     (rd_buf)
   );

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd)); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(bus_wr || bus_rd)); // R14

endmodule

// File: tb/test_stk_cycle_gen.sv
`timescale 1ns/1ps
module test_stk_cycle_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        emu = 1'b0;
   logic        sp_load = 1'b0;
   logic [15:0] sp_load_val = '0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd = '0;
   logic [23:0] op_data = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] bus_addr;
   logic        bus_wr, bus_rd;
   logic [7:0]  bus_wdata;
   logic [23:0] rd_buf;
   logic        busy, done;
   logic [15:0] sp_dbg;

   int vectors = 0;
   int misses  = 0;

   logic [15:0] sp_m;
   logic [7:0]  buf_m [3];

   always #2.5 clk = ~clk;

   function automatic logic [7:0] mem_byte(logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction
   assign bus_rdata = mem_byte(bus_addr);

   stk_cycle_gen i_stk_cycle_gen (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_len(logic [3:0] c);
      case (c)
         4'd6:  return 3;
         4'd7:  return 4;
         4'd8:  return 2;
         4'd9:  return 3;
         4'd10: return 5;
         default: return 1;
      endcase
   endfunction

   // kind: 0 idle, 1 push, 2 pull; returns {kind, full, lane}
   function automatic logic [4:0] exp_step(logic [3:0] c, int i);
      case (c)
         4'd1: return {2'd1, 1'b0, 2'd0};
         4'd2: return {2'd1, 1'b1, 2'd0};
         4'd3, 4'd5: return {2'd2, 1'b0, 2'd0};
         4'd4: return {2'd2, 1'b1, 2'd0};
         4'd6: return (i == 0) ? 5'd0 : {2'd1, 1'b1, 2'(2 - i)};
         4'd7: return (i < 2) ? 5'd0 : {2'd2, 1'b1, 2'(i - 2)};
         4'd8: return {2'd1, 1'b1, 2'(1 - i)};
         4'd9: return {2'd1, 1'b1, 2'(2 - i)};
         4'd10: return (i < 2) ? 5'd0 : {2'd2, 1'b1, 2'(i - 2)};
         default: return 5'd0;
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] c);
      case (c)
         4'd1, 4'd2: return "R2";
         4'd3, 4'd4: return "R3";
         4'd5: return "R6";
         4'd6: return "R7";
         4'd7: return "R8";
         4'd8: return "R9";
         4'd9: return "R10";
         4'd10: return "R11";
         default: return "R14";
      endcase
   endfunction

   task automatic check_state(string tag);
      chk({tag, " sp"}, 32'(sp_dbg), 32'(sp_m));
      chk({tag, " buf"}, 32'(rd_buf), 32'({buf_m[2], buf_m[1], buf_m[0]}));
      chk({tag, " busy"}, 32'(busy), 0);
   endtask

   task automatic set_emu(logic v);
      @(negedge clk);
      if (v && !emu) sp_m[15:8] = 8'h01;
      emu = v;
      @(negedge clk);
      chk("R13 sp after emu change", 32'(sp_dbg), 32'(sp_m));
   endtask

   task automatic load_sp(logic [15:0] v);
      @(negedge clk);
      sp_load = 1'b1; sp_load_val = v;
      cmd_valid = 1'b1; cmd = 4'd2;   // offered with load, must not be accepted
      @(negedge clk);
      sp_load = 1'b0; cmd_valid = 1'b0;
      sp_m = emu ? {8'h01, v[7:0]} : v;
      chk("R12 loaded sp", 32'(sp_dbg), 32'(sp_m));
      chk("R12 no accept with load", 32'(busy), 0);
   endtask

   task automatic run_cmd(logic [3:0] c, logic [23:0] opd, bit jam);
      string t;
      t = tag_of(c);
      @(negedge clk);
      cmd_valid = 1'b1; cmd = c; op_data = opd;
      if (c > 4'd10) begin
         @(negedge clk);
         cmd_valid = 1'b0;
         check_state("R14 unknown code");
         return;
      end
      if (c == 4'd5 && emu) begin
         #1;
         chk("R6 skip done", 32'(done), 1);
         chk("R6 skip strobes", 32'({bus_wr, bus_rd}), 0);
         @(negedge clk);
         cmd_valid = 1'b0;
         check_state("R6 skip");
         return;
      end
      @(negedge clk);
      for (int i = 0; i < exp_len(c); i++) begin
         logic [4:0]  s;
         logic        wrap;
         logic [15:0] ea, ns;
         s    = exp_step(c, i);
         wrap = emu && !s[2];
         ea   = sp_m; ns = sp_m;
         if (s[4:3] == 2'd1) begin
            ea = wrap ? {8'h01, sp_m[7:0]} : sp_m;
            ns = wrap ? {sp_m[15:8], sp_m[7:0] - 8'd1} : sp_m - 16'd1;
         end else if (s[4:3] == 2'd2) begin
            ns = wrap ? {sp_m[15:8], sp_m[7:0] + 8'd1} : sp_m + 16'd1;
            ea = wrap ? {8'h01, ns[7:0]} : ns;
         end
         chk({t, " addr"}, 32'(bus_addr), 32'(ea));
         chk({t, " wr"}, 32'(bus_wr), 32'(s[4:3] == 2'd1));
         chk({t, " rd"}, 32'(bus_rd), 32'(s[4:3] == 2'd2));
         if (s[4:3] == 2'd1) chk({t, " wdata"}, 32'(bus_wdata), 32'(opd[s[1:0]*8 +: 8]));
         chk("R14 busy in step", 32'(busy), 1);
         chk("R14 done in step", 32'(done), 32'(i == exp_len(c) - 1));
         if (s[4:3] == 2'd2) buf_m[s[1:0]] = mem_byte(ea);
         sp_m = ns;
         if (i == exp_len(c) - 1) cmd_valid = 1'b0;
         else if (jam) begin
            cmd_valid = 1'b1; cmd = 4'($urandom_range(1, 10)); op_data = $urandom;
         end else cmd_valid = 1'b0;
         @(negedge clk);
      end
      check_state({t, " after"});
   endtask

   initial begin
      #(200000 * 5);
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      sp_m = 16'h01FF;
      for (int k = 0; k < 3; k++) buf_m[k] = 8'h00;
      check_state("R1 reset");
      chk("R1 strobes", 32'({bus_wr, bus_rd, done}), 0);

      // native mode basics
      load_sp(16'h1234);
      run_cmd(4'd1, 24'h0000C3, 1'b0);
      run_cmd(4'd3, 24'h0, 1'b0);
      run_cmd(4'd2, 24'h00005A, 1'b0);
      run_cmd(4'd4, 24'h0, 1'b0);
      run_cmd(4'd5, 24'h0, 1'b0);          // R6 real pull
      // emulation page edges
      set_emu(1'b1);                        // R13
      load_sp(16'h7F00);                    // R12 becomes 0x0100
      run_cmd(4'd1, 24'h000011, 1'b0);      // R4 wrap down to 0x01FF
      run_cmd(4'd3, 24'h0, 1'b0);           // R4 wrap up to 0x0100
      run_cmd(4'd2, 24'h000022, 1'b0);      // R5 full push -> 0x00FF
      chk("R12 raw high byte", 32'(sp_dbg), 32'h00FF);
      run_cmd(4'd1, 24'h000033, 1'b0);      // R4 page address, high kept 0x00
      run_cmd(4'd5, 24'h0, 1'b0);           // R6 skipped
      run_cmd(4'd4, 24'h0, 1'b0);           // R5 full pull
      // sequences in emulation across page edge
      load_sp(16'h0101);
      run_cmd(4'd9, 24'hABCDEF, 1'b1);      // R10
      run_cmd(4'd10, 24'h0, 1'b1);          // R11
      run_cmd(4'd6, 24'h004455, 1'b1);      // R7
      run_cmd(4'd7, 24'h0, 1'b1);           // R8
      run_cmd(4'd8, 24'h006677, 1'b1);      // R9
      run_cmd(4'd0, 24'h0, 1'b1);
      run_cmd(4'd13, 24'h0, 1'b0);          // R14 unknown
      set_emu(1'b0);
      load_sp(16'h0000);
      run_cmd(4'd6, 24'h008899, 1'b1);      // R7 full borrow
      run_cmd(4'd11, 24'h0, 1'b0);

      for (int n = 0; n < 400; n++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 8) set_emu(~emu);
         else if (r < 14) load_sp(16'($urandom));
         else run_cmd(4'($urandom_range(0, 12)), 24'($urandom), 1'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule